// File: doc/BRIEF.md
# Bus-Matching Width Converter with Endian Select

This block joins a 36-bit long-word data path, on the FIFO side, to a port whose width is 36, 18 or 9 bits. When the port reads, each long-word taken from the FIFO side is handed out as one, two or four narrow transfers. When the port writes, two or four narrow transfers are gathered into one long-word, and that long-word is pushed to the FIFO side. A single width and lane-order setting governs both directions. The FIFO side uses a plain valid/ready handshake in each direction.

The width and the subword order are taken from three configuration inputs while master reset is held low. Partial reset leaves that setting in place. Partial reset clears the narrow output register and both subword positions, so a long-word that is only partly assembled or partly read out is dropped. The port qualifies each transfer with a chip select, an enable and a direction line. It also provides an output-enable that stands in for the tristate control of a bidirectional bus.

Top module: `bus_width_adapter`

## Requirements
- R1: The width is latched from cfg_narrow and cfg_byte while mst_rst_n is low. cfg_narrow=0 gives one 36-bit transfer per long-word. cfg_narrow=1 with cfg_byte=0 gives two 18-bit transfers. cfg_narrow=1 with cfg_byte=1 gives four 9-bit transfers.
- R2: With cfg_msb_first=1 latched, the first transfer of a long-word carries its most significant subword (bits 35:27 for bytes, 35:18 for words), and later transfers carry the less significant subwords in turn. A narrow subword read out appears on port_dout bits [w-1:0], and the upper bits of port_dout are zero.
- R3: With cfg_msb_first=0 latched, the first transfer carries the least significant subword (bits 8:0 or 17:0), and later transfers carry the more significant subwords in turn.
- R4: Write transfers take port_din bits [w-1:0] and ignore the upper bits. Each subword is placed into the lane chosen by the latched order. wr_lw_valid pulses only on the last subword's transfer, and at that moment wr_lw_data holds the full long-word.
- R5: rd_lw_ready (the pop) is high only during the read transfer of the last subword of the long-word at the head. The first subword of the next long-word therefore comes from the following FIFO entry.
- R6: A transfer takes place on a rising clock edge only when port_cs_n=0 and port_en=1. A read transfer also needs rd_lw_valid=1, and a write transfer also needs wr_lw_ready=1. Without a transfer, port_dout and the subword positions stay unchanged.
- R7: Master reset clears port_dout to zero and resets both subword positions to the first subword.
- R8: Partial reset (prt_rst_n=0) clears port_dout and both subword positions and discards any partial long-word. It keeps the width and order latched at master reset, and it ignores the cfg_* inputs.
- R9: port_oe is high exactly when port_cs_n=0 and port_rd=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| mst_rst_n | input | 1 | Master reset, active low, synchronous; latches configuration |
| prt_rst_n | input | 1 | Partial reset, active low, synchronous; keeps configuration |
| cfg_narrow | input | 1 | 0 selects long-word port, 1 selects a narrow port |
| cfg_byte | input | 1 | With cfg_narrow=1: 1 selects 9-bit, 0 selects 18-bit |
| cfg_msb_first | input | 1 | 1 moves the most significant subword first |
| port_cs_n | input | 1 | Chip select, active low |
| port_en | input | 1 | Transfer enable, active high |
| port_rd | input | 1 | Direction: 1 read from block, 0 write into block |
| port_din | input | 36 | Narrow-side write data |
| port_dout | output | 36 | Narrow-side read data register |
| port_oe | output | 1 | Output enable for the narrow-side data bus |
| rd_lw_data | input | 36 | Long-word at the head of the FIFO feeding the port |
| rd_lw_valid | input | 1 | A long-word is available on rd_lw_data |
| rd_lw_ready | output | 1 | Pop strobe for the long-word on rd_lw_data |
| wr_lw_data | output | 36 | Assembled long-word toward the FIFO |
| wr_lw_valid | output | 1 | Push strobe for wr_lw_data |
| wr_lw_ready | input | 1 | The FIFO has room for a long-word |

## Verification
The hardest case to reach is a partial reset that lands partway through a long-word. The setting latched at master reset must survive it, the subword position must restart, and the head long-word must stay unpopped. To reach it, the stimulus runs in byte mode, reads one byte of a long-word or writes two bytes, and then changes the cfg_* inputs to other values. Only then does it pulse partial reset. It then expects the full long-word again, in the original order, from its first subword. The stimulus also drops wr_lw_ready and rd_lw_valid during otherwise valid transfers, which shows that the subword position holds.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

   typedef enum logic [1:0] {
      BWA_LONG = 2'd0,
      BWA_WORD = 2'd1,
      BWA_BYTE = 2'd2
   } bwa_size_e;

   typedef struct packed {
      bwa_size_e size;
      logic      msb_first;
   } bwa_cfg_t;

   function automatic bwa_size_e bwa_decode(input logic narrow, input logic byte_sel);
      if (!narrow)  return BWA_LONG;
      if (byte_sel) return BWA_BYTE;
      return BWA_WORD;
   endfunction

   function automatic logic [1:0] bwa_last(input bwa_size_e size);
      case (size)
         BWA_WORD: return 2'd1;
         BWA_BYTE: return 2'd3;
         default:  return 2'd0;
      endcase
   endfunction

   function automatic logic [1:0] bwa_lane(input logic [1:0] idx, input logic [1:0] last,
                                           input logic msb_first);
      return msb_first ? (last - idx) : idx;
   endfunction

endpackage

// File: rtl/bwa_sub_cnt.sv
module bwa_sub_cnt #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             adv,
   input  logic [CNT_W-1:0] last_idx,
   output logic [CNT_W-1:0] cnt,
   output logic             is_last
);

   assign is_last = (cnt == last_idx);

   always_ff @(posedge clk) begin
      if (clr)          cnt <= '0;
      else if (adv)     cnt <= is_last ? '0 : cnt + 1'b1;
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (clr)
      1'b1 |-> (cnt <= last_idx)); // R1

endmodule

// File: rtl/bwa_unpack.sv
module bwa_unpack
   import bwa_pkg::*;
#(
   parameter int LW_W = 36
) (
   input  logic [LW_W-1:0] lw,
   input  logic [1:0]      lane,
   input  bwa_size_e       size,
   output logic [LW_W-1:0] sub
);

   localparam int BW = LW_W / 4;
   localparam int WW = LW_W / 2;

   logic [BW-1:0] byte_l [4];
   logic [WW-1:0] word_l [2];

   for (genvar g = 0; g < 4; g++) begin : g_byte
      assign byte_l[g] = lw[g*BW +: BW];
   end
   for (genvar g = 0; g < 2; g++) begin : g_word
      assign word_l[g] = lw[g*WW +: WW];
   end

   always_comb begin
      case (size)
         BWA_WORD: sub = LW_W'(word_l[lane[0]]);
         BWA_BYTE: sub = LW_W'(byte_l[lane]);
         default:  sub = lw;
      endcase
   end

endmodule

// File: rtl/bwa_pack.sv
module bwa_pack
   import bwa_pkg::*;
#(
   parameter int LW_W = 36
) (
   input  logic            clk,
   input  logic            clr,
   input  logic            adv,
   input  logic [LW_W-1:0] din,
   input  logic [1:0]      lane,
   input  bwa_size_e       size,
   output logic [LW_W-1:0] merged
);

   localparam int BW = LW_W / 4;
   localparam int WW = LW_W / 2;

   logic [LW_W-1:0] asm_q;

   always_comb begin
      merged = asm_q;
      case (size)
         BWA_WORD: merged[lane[0]*WW +: WW] = din[WW-1:0];
         BWA_BYTE: merged[lane*BW +: BW]    = din[BW-1:0];
         default:  merged = din;
      endcase
   end

   always_ff @(posedge clk) begin
      if (clr)      asm_q <= '0;
      else if (adv) asm_q <= merged;
   end

endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
   import bwa_pkg::*;
#(
   parameter int LW_W = 36
) (
   input  logic            clk,
   input  logic            mst_rst_n,
   input  logic            prt_rst_n,
   input  logic            cfg_narrow,
   input  logic            cfg_byte,
   input  logic            cfg_msb_first,
   input  logic            port_cs_n,
   input  logic            port_en,
   input  logic            port_rd,
   input  logic [LW_W-1:0] port_din,
   output logic [LW_W-1:0] port_dout,
   output logic            port_oe,
   input  logic [LW_W-1:0] rd_lw_data,
   input  logic            rd_lw_valid,
   output logic            rd_lw_ready,
   output logic [LW_W-1:0] wr_lw_data,
   output logic            wr_lw_valid,
   input  logic            wr_lw_ready
);

   localparam int CNT_W = 2;

   if (LW_W < 4 || (LW_W % 4) != 0) begin : g_bad_width
      $error("bus_width_adapter: LW_W must be a positive multiple of 4");
   end

   bwa_cfg_t         cfg_q;
   logic             clr;
   logic [CNT_W-1:0] last_idx;
   logic             xfer_ok;
   logic             rd_xfer, wr_xfer;
   logic [CNT_W-1:0] rd_cnt, wr_cnt;
   logic             rd_last, wr_last;
   logic [1:0]       rd_lane, wr_lane;
   logic [LW_W-1:0]  rd_sub;
   logic [LW_W-1:0]  dout_q;

   always_ff @(posedge clk) begin
      if (!mst_rst_n) begin
         cfg_q.size      <= bwa_decode(cfg_narrow, cfg_byte);
         cfg_q.msb_first <= cfg_msb_first;
      end
   end

   assign clr      = !mst_rst_n || !prt_rst_n;
   assign last_idx = bwa_last(cfg_q.size);
   assign xfer_ok  = !port_cs_n && port_en && !clr;
   assign rd_xfer  = xfer_ok &&  port_rd && rd_lw_valid;
   assign wr_xfer  = xfer_ok && !port_rd && wr_lw_ready;

   bwa_sub_cnt #(.CNT_W(CNT_W)) i_rd_cnt (
      .clk(clk), .clr(clr), .adv(rd_xfer), .last_idx(last_idx),
      .cnt(rd_cnt), .is_last(rd_last));

   bwa_sub_cnt #(.CNT_W(CNT_W)) i_wr_cnt (
      .clk(clk), .clr(clr), .adv(wr_xfer), .last_idx(last_idx),
      .cnt(wr_cnt), .is_last(wr_last));

   assign rd_lane = bwa_lane(rd_cnt, last_idx, cfg_q.msb_first);
   assign wr_lane = bwa_lane(wr_cnt, last_idx, cfg_q.msb_first);

   bwa_unpack #(.LW_W(LW_W)) i_unpack (
      .lw(rd_lw_data), .lane(rd_lane), .size(cfg_q.size), .sub(rd_sub));

   bwa_pack #(.LW_W(LW_W)) i_pack (
      .clk(clk), .clr(clr), .adv(wr_xfer), .din(port_din),
      .lane(wr_lane), .size(cfg_q.size), .merged(wr_lw_data));

   always_ff @(posedge clk) begin
      if (clr)          dout_q <= '0;
      else if (rd_xfer) dout_q <= rd_sub;
   end

   assign port_dout   = dout_q;
   assign port_oe     = !port_cs_n && port_rd;
   assign rd_lw_ready = rd_xfer && rd_last;
   assign wr_lw_valid = wr_xfer && wr_last;

   AST_POP_SPACING: assert property (@(posedge clk) disable iff (clr)
      (rd_lw_ready && cfg_q.size != BWA_LONG) |=> !rd_lw_ready); // R5

   AST_PUSH_SPACING: assert property (@(posedge clk) disable iff (clr)
      (wr_lw_valid && cfg_q.size != BWA_LONG) |=> !wr_lw_valid); // R4

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (clr)
      !rd_xfer |=> $stable(port_dout)); // R6

   AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!mst_rst_n)
      $past(mst_rst_n) |-> $stable(cfg_q)); // R8

   AST_PRS_CLEARS: assert property (@(posedge clk) disable iff (!mst_rst_n)
      !prt_rst_n |=> (port_dout == '0)); // R8

endmodule

// File: tb/test_bus_width_adapter.sv
module test_bus_width_adapter;

   logic        clk = 1'b0;
   logic        mst_rst_n = 1'b0, prt_rst_n = 1'b1;
   logic        cfg_narrow = 1'b0, cfg_byte = 1'b0, cfg_msb_first = 1'b0;
   logic        port_cs_n = 1'b1, port_en = 1'b0, port_rd = 1'b0;
   logic [35:0] port_din = '0;
   logic [35:0] port_dout;
   logic        port_oe;
   logic [35:0] rd_lw_data = '0;
   logic        rd_lw_valid = 1'b0;
   logic        rd_lw_ready;
   logic [35:0] wr_lw_data;
   logic        wr_lw_valid;
   logic        wr_lw_ready = 1'b1;

   int n_chk = 0, n_fail = 0;
   int tb_lanes = 1;
   bit tb_msb = 1'b0;
   logic [35:0] rd_fifo[$];
   logic [35:0] rexp[$];
   logic [35:0] wexp[$];

   always #4 clk = ~clk;

   bus_width_adapter i_bus_width_adapter (.*);

   task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic refresh();
      rd_lw_valid = (rd_fifo.size() != 0);
      rd_lw_data  = (rd_fifo.size() != 0) ? rd_fifo[0] : '0;
   endtask

   function automatic logic [35:0] exp_sub(input logic [35:0] lw, input int k);
      int w    = 36 / tb_lanes;
      int lane = tb_msb ? (tb_lanes - 1 - k) : k;
      logic [35:0] mask = (36'd1 << w) - 36'd1;
      return (lw >> (lane * w)) & mask;
   endfunction

   // FIFO model: pop after the edge that carried rd_lw_ready
   always @(posedge clk) begin
      if (rd_lw_ready) begin
         #1;
         void'(rd_fifo.pop_front());
         refresh();
      end
   end

   // read monitor (R2, R3, R1)
   always @(posedge clk) begin
      if (!port_cs_n && port_en && port_rd && rd_lw_valid && mst_rst_n && prt_rst_n) begin
         #2;
         if (rexp.size() == 0) check("R6 unexpected read", port_dout, 'x);
         else check("R2/R3 read subword", port_dout, rexp.pop_front());
      end
   end

   // write monitor (R4)
   always @(posedge clk) begin
      if (wr_lw_valid) begin
         if (wexp.size() == 0) check("R4 unexpected push", wr_lw_data, 'x);
         else check("R4 assembled long-word", wr_lw_data, wexp.pop_front());
      end
   end

   task automatic idle();
      port_cs_n = 1'b1; port_en = 1'b0; port_rd = 1'b0;
   endtask

   task automatic master_cfg(input bit narrow, input bit bsel, input bit msb);
      @(negedge clk);
      idle();
      cfg_narrow = narrow; cfg_byte = bsel; cfg_msb_first = msb;
      mst_rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R7 dout cleared by master reset", port_dout, '0);
      mst_rst_n = 1'b1;
      cfg_narrow = ~narrow; cfg_byte = ~bsel; cfg_msb_first = ~msb;
      tb_lanes = !narrow ? 1 : (bsel ? 4 : 2);
      tb_msb = msb;
      rd_fifo.delete(); rexp.delete(); wexp.delete(); refresh();
   endtask

   task automatic exp_read(input logic [35:0] lw);
      for (int k = 0; k < tb_lanes; k++) rexp.push_back(exp_sub(lw, k));
   endtask

   task automatic push_read(input logic [35:0] lw);
      rd_fifo.push_back(lw); refresh(); exp_read(lw);
   endtask

   task automatic read_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         port_cs_n = 1'b0; port_en = 1'b1; port_rd = 1'b1;
      end
      @(negedge clk); idle();
   endtask

   task automatic write_subs(input logic [35:0] lw, input int count);
      for (int k = 0; k < count; k++) begin
         @(negedge clk);
         port_cs_n = 1'b0; port_en = 1'b1; port_rd = 1'b0;
         port_din = exp_sub(lw, k) | ((tb_lanes == 1) ? 36'd0 : (36'hFFFFFFFFF << (36 / tb_lanes)));
      end
      @(negedge clk); idle();
   endtask

   task automatic write_lw(input logic [35:0] lw);
      wexp.push_back(lw);
      write_subs(lw, tb_lanes);
   endtask

   task automatic run_mode(input bit narrow, input bit bsel, input bit msb);
      master_cfg(narrow, bsel, msb);
      push_read(36'h9A5C3_1E87); push_read(36'h1_2345_6789);
      read_n(2 * tb_lanes);
      check("R5 FIFO drained after all subwords", 36'(rd_fifo.size()), 36'd0);
      write_lw(36'h8_7654_3210); write_lw(36'hF_0F0F_1234);
      check("R4 all pushes seen", 36'(wexp.size()), 36'd0);
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R7 dout zero after reset", port_dout, '0);
      check("R9 oe low with chip deselected", 36'(port_oe), 36'd0);
      mst_rst_n = 1'b1;

      run_mode(1'b0, 1'b0, 1'b0);   // R1 long-word
      run_mode(1'b1, 1'b0, 1'b1);   // R1 word, R2 msb first
      run_mode(1'b1, 1'b0, 1'b0);   // R3 word lsb first
      run_mode(1'b1, 1'b1, 1'b1);   // R2 byte msb first
      run_mode(1'b1, 1'b1, 1'b0);   // R3 byte lsb first

      // R5: pop only after the last subword
      master_cfg(1'b1, 1'b1, 1'b1);
      push_read(36'hABC_DEF_012);
      read_n(3);
      check("R5 no pop before last subword", 36'(rd_fifo.size()), 36'd1);
      read_n(1);
      check("R5 pop on last subword", 36'(rd_fifo.size()), 36'd0);

      // R6: disqualified transfers leave dout unchanged
      push_read(36'h1_1111_2222);
      read_n(1);
      @(negedge clk); port_cs_n = 1'b1; port_en = 1'b1; port_rd = 1'b1;
      @(negedge clk); port_cs_n = 1'b0; port_en = 1'b0;
      @(negedge clk); idle();
      check("R6 dout held when deselected", port_dout, exp_sub(36'h1_1111_2222, 0));
      check("R6 no pop when deselected", 36'(rd_fifo.size()), 36'd1);
      read_n(3);
      read_n(1);  // FIFO empty: no transfer
      check("R6 dout held with FIFO empty", port_dout, exp_sub(36'h1_1111_2222, 3));

      // R6: write ignored while wr_lw_ready low
      wr_lw_ready = 1'b0;
      write_subs(36'h5_5555_5555, 4);
      wr_lw_ready = 1'b1;
      write_lw(36'h3_0102_0304);
      check("R6 write while not ready ignored", 36'(wexp.size()), 36'd0);

      // R8: partial reset mid long-word keeps config, restarts subwords
      push_read(36'hC_AFE_BABE);
      read_n(1);
      write_subs(36'h7_7777_7777, 2);
      @(negedge clk);
      cfg_narrow = 1'b0; cfg_byte = 1'b0; cfg_msb_first = 1'b0;
      prt_rst_n = 1'b0;
      @(negedge clk);
      check("R8 dout cleared by partial reset", port_dout, '0);
      prt_rst_n = 1'b1;
      check("R8 head long-word not popped", 36'(rd_fifo.size()), 36'd1);
      rexp.delete(); exp_read(36'hC_AFE_BABE);
      read_n(4);
      check("R8 re-read complete", 36'(rexp.size()), 36'd0);
      write_lw(36'h2_468A_CE13);
      check("R8 partial write discarded", 36'(wexp.size()), 36'd0);

      // R9: output enable
      @(negedge clk); port_cs_n = 1'b0; port_rd = 1'b1; port_en = 1'b0;
      #1 check("R9 oe high when selected for read", 36'(port_oe), 36'd1);
      port_rd = 1'b0;
      #1 check("R9 oe low when writing", 36'(port_oe), 36'd0);
      idle();

      repeat (3) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule